// File: doc/BRIEF.md
# Byte-Stream Packet Deframer with Escape Removal

This block sits on a byte stream that carries packets in the common serial-line framing scheme: one reserved code marks the end of a packet, and a second reserved code introduces a two-byte escape so that the reserved values can still appear in the payload. Each accepted input byte is qualified by a valid strobe. The block strips the framing, undoes the escapes and delivers the payload as a byte stream. The final byte of each packet is flagged as last.

All four code values can be changed at run time: the terminator, the escape introducer, and the two substitutes that follow an escape. A substitute byte after an escape stands for the terminator value or the escape value. A byte after an escape that is not one of the two substitutes is discarded. A packet only ends when its terminator arrives, so the block holds back one decoded byte. That byte is released when the next decoded byte or the terminator arrives, and the last flag goes out with it. When a terminator arrives and no byte is held, the block emits a single zero-length marker.

Top module: `slip_deframer`

## Requirements
- R1: An input byte equal to the terminator code, seen with no escape pending, closes the packet. On the clock after it is accepted, out_valid=1 and out_last=1, and the byte held back is released on out_byte.
- R2: An input byte equal to the escape code, seen with no escape pending, produces no output on the following clock and makes the next accepted byte an escaped byte.
- R3: An escaped byte clears the escape state. If it equals the terminator substitute, the terminator code value is added to the packet. If it equals the escape substitute, the escape code value is added. The terminator substitute is compared first.
- R4: An escaped byte that matches neither substitute adds nothing to the packet. The byte after it is decoded normally.
- R5: Decoding checks three conditions in this order: escape pending, then escape code, then terminator code. An escaped byte equal to the terminator or the escape code (and to neither substitute) is dropped. It neither closes the packet nor starts a new escape.
- R6: Any other byte is added to the packet unchanged. Output is one decoded byte behind the input. The first decoded byte of a packet causes no output. Each later decoded byte releases the previously held byte with out_last=0 on the clock after acceptance. out_valid lasts one clock per released byte.
- R7: A terminator that arrives with no byte held produces a zero-length marker: out_valid=1, out_empty=1, out_last=1, out_byte=0. out_empty is 0 on every other output.
- R8: A clock with in_valid=0 changes no state and produces out_valid=0.
- R9: Synchronous active-high reset clears the escape state, discards any held byte and drives out_valid, out_last and out_empty to 0.
- R10: The four code values come from input ports and take effect on the next accepted byte. A value that is reserved under one configuration is plain data under another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Input byte |
| code_end | input | 8 | Terminator code |
| code_esc | input | 8 | Escape introducer code |
| code_sub_end | input | 8 | Substitute meaning the terminator value |
| code_sub_esc | input | 8 | Substitute meaning the escape value |
| out_valid | output | 1 | Decoded output strobe (one clock) |
| out_byte | output | 8 | Decoded byte, 0 on an empty marker |
| out_last | output | 1 | Final byte of packet, or empty marker |
| out_empty | output | 1 | Zero-length packet marker |

## Verification
The bench sends back-to-back terminators, so an empty packet that produced no marker, or a stale byte released as data, would show as a count mismatch. It sends an escape followed by the terminator code, and then by the escape code itself. A decoder that got the order of checks wrong would close the packet early or stay stuck in the escape state. It resets in mid-escape and in mid-packet, where a flag or held byte that survived would turn a plain byte into a substitute or put a stale byte on the output. It then swaps in a second set of codes, so that a value hard-wired as reserved would be lost where it should pass as data.

// File: rtl/slip_pkg.sv
package slip_pkg;

    localparam int SYM_W = 8;

    typedef logic [SYM_W-1:0] sym_t;

    // Outcome of decoding one accepted byte
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_DATA  = 2'd1,
        ACT_CLOSE = 2'd2
    } act_kind_e;

    typedef struct packed {
        act_kind_e kind;
        sym_t      value;
    } act_t;

    typedef struct packed {
        sym_t term;
        sym_t esc;
        sym_t sub_term;
        sym_t sub_esc;
    } codes_t;

    typedef struct packed {
        logic valid;
        sym_t data;
        logic last;
        logic empty;
    } beat_t;

    localparam beat_t BEAT_IDLE = '{valid: 1'b0, data: '0, last: 1'b0, empty: 1'b0};

endpackage

// File: rtl/slip_unescape.sv
module slip_unescape
    import slip_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  sym_t   in_byte,
    input  codes_t codes,
    output act_t   act,
    output logic   esc_pending
);

    logic esc_next;

    always_comb begin
        act      = '{kind: ACT_NONE, value: '0};
        esc_next = esc_pending;
        if (in_valid) begin
            if (esc_pending) begin
                esc_next = 1'b0;
                if (in_byte == codes.sub_term) begin
                    act = '{kind: ACT_DATA, value: codes.term};
                end else if (in_byte == codes.sub_esc) begin
                    act = '{kind: ACT_DATA, value: codes.esc};
                end
            end else if (in_byte == codes.esc) begin
                esc_next = 1'b1;
            end else if (in_byte == codes.term) begin
                act.kind = ACT_CLOSE;
            end else begin
                act = '{kind: ACT_DATA, value: in_byte};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            esc_pending <= 1'b0;
        end else begin
            esc_pending <= esc_next;
        end
    end

    AST_ESC_ARMS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !esc_pending && in_byte == codes.esc) |=> esc_pending); // R2
    AST_ESC_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && esc_pending) |=> !esc_pending); // R3
    AST_IDLE_KEEPS_ESC: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(esc_pending)); // R8

endmodule

// File: rtl/slip_emit.sv
module slip_emit
    import slip_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  act_t  act,
    output beat_t beat
);

    logic  held_valid;
    sym_t  held_byte;
    beat_t beat_next;
    logic  held_valid_next;
    sym_t  held_byte_next;

    always_comb begin
        beat_next       = BEAT_IDLE;
        held_valid_next = held_valid;
        held_byte_next  = held_byte;
        unique case (act.kind)
            ACT_DATA: begin
                if (held_valid) begin
                    beat_next = '{valid: 1'b1, data: held_byte, last: 1'b0, empty: 1'b0};
                end
                held_valid_next = 1'b1;
                held_byte_next  = act.value;
            end
            ACT_CLOSE: begin
                if (held_valid) begin
                    beat_next = '{valid: 1'b1, data: held_byte, last: 1'b1, empty: 1'b0};
                end else begin
                    beat_next = '{valid: 1'b1, data: '0, last: 1'b1, empty: 1'b1};
                end
                held_valid_next = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat       <= BEAT_IDLE;
            held_valid <= 1'b0;
            held_byte  <= '0;
        end else begin
            beat       <= beat_next;
            held_valid <= held_valid_next;
            held_byte  <= held_byte_next;
        end
    end

    AST_CLOSE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (act.kind == ACT_CLOSE) |=> (beat.valid && beat.last)); // R1
    AST_FIRST_BYTE_HELD: assert property (@(posedge clk) disable iff (rst)
        (act.kind == ACT_DATA && !held_valid) |=> !beat.valid); // R6
    AST_EMPTY_MARKER: assert property (@(posedge clk) disable iff (rst)
        beat.empty |-> (beat.valid && beat.last && beat.data == '0)); // R7
    AST_NO_ACT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (act.kind == ACT_NONE) |=> !beat.valid); // R8

endmodule

// File: rtl/slip_deframer.sv
module slip_deframer
    import slip_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [SYM_W-1:0] in_byte,
    input  logic [SYM_W-1:0] code_end,
    input  logic [SYM_W-1:0] code_esc,
    input  logic [SYM_W-1:0] code_sub_end,
    input  logic [SYM_W-1:0] code_sub_esc,
    output logic             out_valid,
    output logic [SYM_W-1:0] out_byte,
    output logic             out_last,
    output logic             out_empty
);

    codes_t codes;
    act_t   act;
    logic   esc_pending;
    beat_t  beat;

    assign codes = '{term: code_end, esc: code_esc,
                     sub_term: code_sub_end, sub_esc: code_sub_esc};

    slip_unescape u_unescape (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_byte     (in_byte),
        .codes       (codes),
        .act         (act),
        .esc_pending (esc_pending)
    );

    slip_emit u_emit (
        .clk  (clk),
        .rst  (rst),
        .act  (act),
        .beat (beat)
    );

    assign out_valid = beat.valid;
    assign out_byte  = beat.data;
    assign out_last  = beat.last;
    assign out_empty = beat.empty;

    AST_ESC_SILENT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !esc_pending && in_byte == code_esc) |=> !out_valid); // R2
    AST_BAD_ESCAPE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && esc_pending && in_byte != code_sub_end && in_byte != code_sub_esc)
        |=> !out_valid); // R4
    AST_IDLE_NO_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R8
    AST_OUT_AFTER_INPUT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid)); // R6

endmodule

// File: tb/slip_deframer_tb.sv
module slip_deframer_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [7:0] in_byte;
    logic [7:0] code_end, code_esc, code_sub_end, code_sub_esc;
    logic       out_valid;
    logic [7:0] out_byte;
    logic       out_last;
    logic       out_empty;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk; // 50 MHz

    slip_deframer u_dut (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_byte      (in_byte),
        .code_end     (code_end),
        .code_esc     (code_esc),
        .code_sub_end (code_sub_end),
        .code_sub_esc (code_sub_esc),
        .out_valid    (out_valid),
        .out_byte     (out_byte),
        .out_last     (out_last),
        .out_empty    (out_empty)
    );

    // {req[3:0], in_byte[7:0], exp_valid, exp_byte[7:0], exp_last, exp_empty}
    // default codes: terminator C0, escape DB, sub-terminator DC, sub-escape DD
    localparam logic [22:0] VEC [19] = '{
        {4'd7,  8'hC0, 1'b1, 8'h00, 1'b1, 1'b1},  // R7 empty marker
        {4'd6,  8'h11, 1'b0, 8'h00, 1'b0, 1'b0},  // R6 first byte held
        {4'd6,  8'h22, 1'b1, 8'h11, 1'b0, 1'b0},  // R6 release, not last
        {4'd1,  8'hC0, 1'b1, 8'h22, 1'b1, 1'b0},  // R1 close with last
        {4'd2,  8'hDB, 1'b0, 8'h00, 1'b0, 1'b0},  // R2 escape silent
        {4'd3,  8'hDC, 1'b0, 8'h00, 1'b0, 1'b0},  // R3 held = C0
        {4'd2,  8'hDB, 1'b0, 8'h00, 1'b0, 1'b0},  // R2
        {4'd3,  8'hDD, 1'b1, 8'hC0, 1'b0, 1'b0},  // R3 held = DB
        {4'd3,  8'hC0, 1'b1, 8'hDB, 1'b1, 1'b0},  // R3
        {4'd6,  8'h33, 1'b0, 8'h00, 1'b0, 1'b0},  // R6
        {4'd2,  8'hDB, 1'b0, 8'h00, 1'b0, 1'b0},  // R2
        {4'd4,  8'h55, 1'b0, 8'h00, 1'b0, 1'b0},  // R4 dropped
        {4'd4,  8'hC0, 1'b1, 8'h33, 1'b1, 1'b0},  // R4 escape cleared
        {4'd2,  8'hDB, 1'b0, 8'h00, 1'b0, 1'b0},  // R2
        {4'd5,  8'hC0, 1'b0, 8'h00, 1'b0, 1'b0},  // R5 escaped terminator dropped
        {4'd5,  8'h44, 1'b0, 8'h00, 1'b0, 1'b0},  // R5 plain data held
        {4'd2,  8'hDB, 1'b0, 8'h00, 1'b0, 1'b0},  // R2
        {4'd5,  8'hDB, 1'b0, 8'h00, 1'b0, 1'b0},  // R5 escaped escape dropped
        {4'd5,  8'hC0, 1'b1, 8'h44, 1'b1, 1'b0}   // R5 not re-armed
    };

    task automatic check(input int req, input logic v, input logic [7:0] b,
                         input logic l, input logic e);
        total++;
        if (out_valid !== v || (v && (out_byte !== b || out_last !== l || out_empty !== e))) begin
            bad++;
            $display("FAIL R%0d: got v=%b b=%h l=%b e=%b, expected v=%b b=%h l=%b e=%b",
                     req, out_valid, out_byte, out_last, out_empty, v, b, l, e);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'hC0;
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst      = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        #3_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_byte = '0;
        code_end = 8'hC0; code_esc = 8'hDB; code_sub_end = 8'hDC; code_sub_esc = 8'hDD;
        do_reset();
        #1;
        check(9, 1'b0, 8'h00, 1'b0, 1'b0); // R9 reset state

        for (int i = 0; i < 19; i++) begin
            push(VEC[i][18:11]);
            check(int'(VEC[i][22:19]), VEC[i][10], VEC[i][9:2], VEC[i][1], VEC[i][0]);
        end

        // R8: idle clocks neither output nor disturb held byte
        push(8'h66);  check(8, 1'b0, 8'h00, 1'b0, 1'b0);
        idle();       check(8, 1'b0, 8'h00, 1'b0, 1'b0);
        idle();       check(8, 1'b0, 8'h00, 1'b0, 1'b0);
        push(8'hC0);  check(8, 1'b1, 8'h66, 1'b1, 1'b0);
        idle();       check(6, 1'b0, 8'h00, 1'b0, 1'b0); // R6 one-clock pulse

        // R8: idle between escape and substitute keeps escape pending
        push(8'hDB);  check(8, 1'b0, 8'h00, 1'b0, 1'b0);
        idle();
        push(8'hDC);  check(8, 1'b0, 8'h00, 1'b0, 1'b0);
        push(8'hC0);  check(8, 1'b1, 8'hC0, 1'b1, 1'b0);

        // R9: reset mid-escape with a held byte
        push(8'h77);
        push(8'hDB);
        do_reset();
        push(8'hDC);  check(9, 1'b0, 8'h00, 1'b0, 1'b0);
        push(8'hC0);  check(9, 1'b1, 8'hDC, 1'b1, 1'b0);
        push(8'h88);
        do_reset();
        push(8'hC0);  check(9, 1'b1, 8'h00, 1'b1, 1'b1);

        // R10: alternate code set
        code_end = 8'h7E; code_esc = 8'h7D; code_sub_end = 8'h5E; code_sub_esc = 8'h5D;
        push(8'h7D);  check(10, 1'b0, 8'h00, 1'b0, 1'b0);
        push(8'h5E);  check(10, 1'b0, 8'h00, 1'b0, 1'b0);
        push(8'hC0);  check(10, 1'b1, 8'h7E, 1'b0, 1'b0);
        push(8'h7D);  check(10, 1'b0, 8'h00, 1'b0, 1'b0);
        push(8'h5D);  check(10, 1'b1, 8'hC0, 1'b0, 1'b0);
        push(8'hDB);  check(10, 1'b1, 8'h7D, 1'b0, 1'b0);
        push(8'h7E);  check(10, 1'b1, 8'hDB, 1'b1, 1'b0);
        push(8'h7E);  check(10, 1'b1, 8'h00, 1'b1, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule